// File: doc/BRIEF.md
# Multi-Region Console Clock-Enable Divider

This block derives two clock-enable strobes from a single master oscillator clock: one for the picture-processor dot rate and one for the CPU rate. The divide ratios depend on a two-bit region select that picks one of three timing families: a 60 Hz family, a 50 Hz family, and a 50 Hz clone family that keeps an integer dot-to-CPU ratio. All logic runs in the master clock domain. Downstream logic advances only on cycles where its enable is high, so no derived clocks are created.

In the 60 Hz and 50 Hz families the CPU strobe comes from a twisted-ring (Johnson) counter, which can only give even periods. The clone family needs an odd period of fifteen, so its CPU strobe comes from a separate binary modulo counter. A small phase tracker counts dot strobes since the most recent CPU strobe. This makes the non-integer 16:5 relation of the 50 Hz family visible at the ports.

The region select is captured only while reset is held. The chosen ratios then stay fixed until the next reset.

Top module: `region_clock_div`

## Requirements
- R1: With region code 0, `dot_en` pulses on every 4th master cycle and `cpu_en` on every 12th, giving three dots per CPU cycle.
- R2: With region code 1, `dot_en` pulses on every 5th master cycle and `cpu_en` on every 16th.
- R3: With region code 2, `dot_en` pulses on every 5th master cycle and `cpu_en` on every 15th.
- R4: Region code 3 is reserved and gives exactly the timing of region code 0.
- R5: While `rst` is high, both enables are low and `dot_phase` is 0. In the first master cycle with `rst` low, `dot_en` and `cpu_en` are both high. Counting that cycle as cycle 0, dot pulses fall on cycles that are multiples of the dot period, and CPU pulses fall on multiples of the CPU period.
- R6: Neither enable is ever high on two consecutive master cycles.
- R7: `dot_phase` is a registered count. In a cycle that follows a `cpu_en` cycle, it reads 1 if `dot_en` was also high in that `cpu_en` cycle, and 0 otherwise. In any other cycle, it reads its previous value plus 1 when `dot_en` was high in the previous cycle, and its previous value otherwise. It never exceeds 4.
- R8: With region code 1, any 80 consecutive master cycles after reset contain exactly 16 dot pulses and 5 CPU pulses.
- R9: `region_sel` is captured only while `rst` is high. A change to it while `rst` is low has no effect on either enable or on `dot_phase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous active-high reset; region is captured while high |
| region_sel | input | 2 | 0: 60 Hz family, 1: 50 Hz family, 2: clone family, 3: reserved (as 0) |
| dot_en | output | 1 | Dot-rate clock-enable strobe, one master cycle wide |
| cpu_en | output | 1 | CPU-rate clock-enable strobe, one master cycle wide |
| dot_phase | output | 3 | Dot strobes seen since the last CPU strobe |

## Verification
Both enables are decoded combinationally from registered counters. They are therefore due in the same master cycle that the counters reach zero, starting with cycle 0, the first cycle after `rst` falls. `dot_phase` is one register later: it reflects the strobes of the preceding cycle. The bench drives inputs on the falling edge and samples one nanosecond after it. It numbers cycles from the release of reset and compares each cycle's sample against a behavioural model indexed by that cycle number. The phase model is updated only after each comparison, which keeps its one-cycle lag.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    localparam int DOT_W   = 3;  // holds dot divide up to 7
    localparam int J_STAGES = 8; // Johnson stages, max even period 16
    localparam int JIDX_W  = $clog2(J_STAGES);
    localparam int ODD_W   = 4;  // odd divide counter width
    localparam int PH_W    = 3;  // dot phase width

    typedef enum logic [1:0] {
        REG_SIXTY = 2'd0,
        REG_FIFTY = 2'd1,
        REG_CLONE = 2'd2,
        REG_RSVD  = 2'd3
    } region_e;

    typedef struct packed {
        logic [DOT_W-1:0]  dot_div;  // dot period in master cycles
        logic              cpu_odd;  // use binary counter for CPU
        logic [JIDX_W-1:0] j_last;   // last active Johnson stage
        logic [ODD_W-1:0]  odd_div;  // binary CPU period
    } ratio_t;

    function automatic ratio_t ratio_of(input region_e r);
        ratio_t x;
        case (r)
            REG_FIFTY: x = '{dot_div: DOT_W'(5), cpu_odd: 1'b0,
                             j_last: JIDX_W'(7), odd_div: ODD_W'(15)};
            REG_CLONE: x = '{dot_div: DOT_W'(5), cpu_odd: 1'b1,
                             j_last: JIDX_W'(7), odd_div: ODD_W'(15)};
            default:   x = '{dot_div: DOT_W'(4), cpu_odd: 1'b0,
                             j_last: JIDX_W'(5), odd_div: ODD_W'(15)};
        endcase
        return x;
    endfunction

endpackage

// File: rtl/ccd_mod_counter.sv
module ccd_mod_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (cnt == div - 1'b1)  cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == '0);

    p_tick_no_repeat_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && div > W'(1)) |=> !tick);
endmodule

// File: rtl/ccd_johnson_div.sv
module ccd_johnson_div #(
    parameter int STAGES = 8,
    parameter int IW     = $clog2(STAGES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] last,
    output logic          tick
);
    logic [STAGES-1:0] q, nxt;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign nxt[0] = ~q[last];
            end else begin : g_body
                assign nxt[i] = (IW'(i) <= last) ? q[i-1] : 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign tick = (q == '0);

    p_jtick_no_repeat_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    p_ring_shape_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(q ^ (q >> 1)) <= 2);
endmodule

// File: rtl/ccd_phase_track.sv
module ccd_phase_track #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dot_en,
    input  logic          cpu_en,
    output logic [PW-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst)         phase <= '0;
        else if (cpu_en) phase <= dot_en ? PW'(1) : '0;
        else if (dot_en) phase <= phase + 1'b1;
    end

    p_phase_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_en |=> (phase == ($past(dot_en) ? PW'(1) : PW'(0))));
endmodule

// File: rtl/region_clock_div.sv
module region_clock_div
    import ccd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] region_sel,
    output logic       dot_en,
    output logic       cpu_en,
    output logic [2:0] dot_phase
);
    region_e region_q;
    ratio_t  rat;
    logic    dot_tick, even_tick, odd_tick;

    always_ff @(posedge clk) begin
        if (rst) region_q <= region_e'(region_sel);
    end

    assign rat = ratio_of(region_q);

    ccd_mod_counter #(.W(DOT_W)) u_dot (
        .clk(clk), .rst(rst), .div(rat.dot_div), .tick(dot_tick));

    ccd_johnson_div #(.STAGES(J_STAGES), .IW(JIDX_W)) u_even (
        .clk(clk), .rst(rst), .last(rat.j_last), .tick(even_tick));

    ccd_mod_counter #(.W(ODD_W)) u_odd (
        .clk(clk), .rst(rst), .div(rat.odd_div), .tick(odd_tick));

    assign dot_en = dot_tick & ~rst;
    assign cpu_en = (rat.cpu_odd ? odd_tick : even_tick) & ~rst;

    ccd_phase_track #(.PW(PH_W)) u_phase (
        .clk(clk), .rst(rst), .dot_en(dot_en), .cpu_en(cpu_en),
        .phase(dot_phase));

    p_reset_quiet_r5: assert property (@(posedge clk)
        rst |-> (!dot_en && !cpu_en));
    p_release_aligned_r5: assert property (@(posedge clk)
        $fell(rst) |-> (dot_en && cpu_en));
    p_dot_single_r6: assert property (@(posedge clk) disable iff (rst)
        dot_en |=> !dot_en);
    p_cpu_single_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_en |=> !cpu_en);
    p_phase_bound_r7: assert property (@(posedge clk) disable iff (rst)
        dot_phase <= 3'd4);
    p_region_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$fell(rst) |-> $stable(region_q));
endmodule

// File: tb/sim_region_clock_div.sv
module sim_region_clock_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] region_sel = 2'd0;
    logic       dot_en, cpu_en;
    logic [2:0] dot_phase;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    region_clock_div u0 (
        .clk(clk), .rst(rst), .region_sel(region_sel),
        .dot_en(dot_en), .cpu_en(cpu_en), .dot_phase(dot_phase));

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // run one region: hold reset, release, compare every cycle
    task automatic run_region(input logic [1:0] sel, input string req,
                              input int cycles, input int swap_at,
                              input logic [1:0] swap_to);
        int dp, cp, ph, ndot, ncpu;
        bit pd, pc;
        dp = (sel == 2'd0 || sel == 2'd3) ? 4 : 5;
        cp = (sel == 2'd1) ? 16 : (sel == 2'd2) ? 15 : 12;
        @(negedge clk);
        rst = 1'b1;
        region_sel = sel;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            check("R5", "dot_en in reset", int'(dot_en), 0);
            check("R5", "cpu_en in reset", int'(cpu_en), 0);
            check("R5", "dot_phase in reset", int'(dot_phase), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        ph = 0; ndot = 0; ncpu = 0; pd = 0; pc = 0;
        for (int t = 0; t < cycles; t++) begin
            bit ed, ec;
            if (t != 0) @(negedge clk);
            #1;
            ed = (t % dp) == 0;
            ec = (t % cp) == 0;
            check(req, "dot_en", int'(dot_en), int'(ed));
            check(req, "cpu_en", int'(cpu_en), int'(ec));
            check("R7", "dot_phase", int'(dot_phase), ph);
            if (t == 0) begin
                check("R5", "first dot_en", int'(dot_en), 1);
                check("R5", "first cpu_en", int'(cpu_en), 1);
            end
            if (pd && dot_en) check("R6", "dot_en repeat", 1, 0);
            if (pc && cpu_en) check("R6", "cpu_en repeat", 1, 0);
            pd = dot_en; pc = cpu_en;
            if (t < 80) begin
                ndot += int'(dot_en);
                ncpu += int'(cpu_en);
            end
            if (ec) ph = ed ? 1 : 0;
            else if (ed) ph = ph + 1;
            if (t == swap_at) region_sel = swap_to;
        end
        if (sel == 2'd1) begin
            check("R8", "dots in 80 cycles", ndot, 16);
            check("R8", "cpus in 80 cycles", ncpu, 5);
        end
    endtask

    initial begin
        run_region(2'd0, "R1", 240, -1, 2'd0);
        run_region(2'd1, "R2", 320, -1, 2'd1);
        run_region(2'd2, "R3", 300, -1, 2'd2);
        run_region(2'd3, "R4", 240, -1, 2'd3);
        // R9: region changes while running must be ignored
        run_region(2'd2, "R9", 300, 37, 2'd0);
        run_region(2'd1, "R9", 320, 50, 2'd2);
        run_region(2'd0, "R9", 240, 20, 2'd1);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule